// File: doc/BRIEF.md
# Board Mode and Status-LED Controller

This block chooses the operating mode of a development board from one mode push-button and shows the mode and the progress of uploads and programming on a three-channel status LED. When reset ends, the button is sampled through a synchroniser and a debounce filter. If it is found held down, the board enters a firmware-update mode. Otherwise it enters development mode. After that, each clean press toggles between development mode and an advanced mode. In advanced mode a sub-command input picks between terminal, test and flash operation.

Upload and programming activity reach the block only as single-cycle strobes from the logic that does the work. The red and green channels show a priority overlay: upload activity first, then programming progress (amber, shown as red and green together), then a green non-default mode marker, then off. Application logic owns the blue channel, so a blinking blue alternates between "mode colour plus blue" and "mode colour alone".

Top module: `board_status_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `mode_o` is 2'b00, `sub_o` is 2'b00 and the red and green LEDs are off.
- R2: If the button (active high) stays pressed from reset release until its level settles, `mode_o` becomes 2'b10 (firmware update). If it stays released, `mode_o` stays 2'b00 (development). The level held at startup does not count as a press.
- R3: After startup, each debounced press of the button (a rising edge of the filtered level) moves development (2'b00) to advanced (2'b01) and advanced back to development. `mode_o` is never 2'b11.
- R4: Firmware-update mode ignores every further press and is left only through reset.
- R5: A button level is accepted only after STABLE_CNT equal samples taken on consecutive slow ticks, one tick every TICK_DIV clocks. A pulse shorter than TICK_DIV clocks never changes the mode.
- R6: In advanced mode, `sub_o` copies `sub_sel_i` one clock later (0 idle, 1 terminal, 2 test, 3 flash). In any other mode it reads 0.
- R7: `upl_start_i` makes the LED red only (red on, green off) from the next cycle. `upl_done_i` during an upload turns red off. `upl_err_i` during an upload keeps red on through later done strobes until the next `upl_start_i`. A start strobe wins over a done or error strobe in the same cycle.
- R8: Outside development mode, `prg_start_i` shows amber (red and green on) from the next cycle until `prg_done_i`. Without a done strobe, amber stays on. Programming strobes have no effect in development mode.
- R9: With no upload or programming indication, the LED is green in advanced and firmware-update modes and dark in development mode. Upload indication takes priority over amber, and amber takes priority over green.
- R10: `led_b_o` follows `usr_blue_i` in the same cycle and does not affect red or green.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| btn_i | input | 1 | Raw mode button, high while pressed, asynchronous |
| upl_start_i | input | 1 | Upload started strobe |
| upl_done_i | input | 1 | Upload finished strobe |
| upl_err_i | input | 1 | Upload failed strobe |
| prg_start_i | input | 1 | Programming started strobe |
| prg_done_i | input | 1 | Programming finished strobe |
| sub_sel_i | input | 2 | Advanced sub-command select |
| usr_blue_i | input | 1 | Blue channel from application logic |
| mode_o | output | 2 | Mode code: 00 development, 01 advanced, 10 firmware update |
| sub_o | output | 2 | Active advanced sub-command |
| led_r_o | output | 1 | Red LED drive |
| led_g_o | output | 1 | Green LED drive |
| led_b_o | output | 1 | Blue LED drive |

## Verification
A wrong debounce or startup state shows at `mode_o` a few hundred clocks after reset or after a press: the startup mode comes out wrong, a glitch toggles the mode, or firmware-update mode lets go. A wrong upload or programming state shows on the red and green pins in the cycle after the strobe that caused it. The error-latch and amber-hold cases show only after a later strobe that should not clear them, so the bench sends those strobes on purpose. A faulty sub-command register shows on `sub_o` one clock after `sub_sel_i` changes.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic [1:0] {
        MODE_DEV = 2'b00,
        MODE_ADV = 2'b01,
        MODE_FWU = 2'b10
    } mode_e;

    typedef enum logic [1:0] {
        SUB_IDLE  = 2'b00,
        SUB_TERM  = 2'b01,
        SUB_TEST  = 2'b10,
        SUB_FLASH = 2'b11
    } sub_e;

    typedef enum logic [1:0] {
        UPL_IDLE = 2'b00,
        UPL_BUSY = 2'b01,
        UPL_FAIL = 2'b10
    } upl_e;

    typedef struct packed {
        logic r;
        logic g;
        logic b;
    } rgb_t;

    // Priority overlay: upload, then programming amber, then mode green, then off.
    function automatic rgb_t pick_colour(upl_e upl, logic prog, mode_e mode, logic blue);
        rgb_t c;
        c.b = blue;
        if (upl != UPL_IDLE) begin
            c.r = 1'b1;
            c.g = 1'b0;
        end else if (prog && mode != MODE_DEV) begin
            c.r = 1'b1;
            c.g = 1'b1;
        end else if (mode != MODE_DEV) begin
            c.r = 1'b0;
            c.g = 1'b1;
        end else begin
            c.r = 1'b0;
            c.g = 1'b0;
        end
        return c;
    endfunction

endpackage

// File: rtl/bsc_tick.sv
module bsc_tick #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(TICK_DIV);
            localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            assign tick_o = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/bsc_debounce.sv
module bsc_debounce #(
    parameter int STABLE_CNT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic btn_i,
    output logic lvl_o,
    output logic valid_o,
    output logic rise_o
);
    localparam int CW = $clog2(STABLE_CNT + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CNT - 1);

    logic [1:0]    sync_q;
    logic          smp;
    logic          prev_q;
    logic [CW-1:0] cnt_q;
    logic          lvl_q;
    logic          valid_q;
    logic          rise_q;

    assign smp = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '0;
            prev_q  <= 1'b0;
            cnt_q   <= '0;
            lvl_q   <= 1'b0;
            valid_q <= 1'b0;
            rise_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], btn_i};
            rise_q <= 1'b0;
            if (tick_i) begin
                prev_q <= smp;
                if (smp != prev_q) begin
                    cnt_q <= '0;
                end else if (valid_q && smp == lvl_q) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q   <= '0;
                    lvl_q   <= smp;
                    valid_q <= 1'b1;
                    rise_q  <= valid_q && smp;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign lvl_o   = lvl_q;
    assign valid_o = valid_q;
    assign rise_o  = rise_q;

    // R5
    lvl_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(lvl_q));

    // R2
    no_boot_press_chk: assert property (@(posedge clk) disable iff (rst)
        rise_q |-> $past(valid_q));

endmodule

// File: rtl/bsc_mode_fsm.sv
module bsc_mode_fsm
    import bsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl_i,
    input  logic       valid_i,
    input  logic       rise_i,
    input  logic [1:0] sub_sel_i,
    output mode_e      mode_o,
    output sub_e       sub_o
);
    mode_e mode_q, mode_nx;
    sub_e  sub_q;
    logic  boot_q;

    always_comb begin
        mode_nx = mode_q;
        if (!boot_q) begin
            if (valid_i) begin
                mode_nx = lvl_i ? MODE_FWU : MODE_DEV;
            end
        end else if (rise_i) begin
            case (mode_q)
                MODE_DEV: mode_nx = MODE_ADV;
                MODE_ADV: mode_nx = MODE_DEV;
                default:  mode_nx = mode_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_DEV;
            boot_q <= 1'b0;
            sub_q  <= SUB_IDLE;
        end else begin
            mode_q <= mode_nx;
            boot_q <= boot_q | valid_i;
            sub_q  <= (mode_nx == MODE_ADV) ? sub_e'(sub_sel_i) : SUB_IDLE;
        end
    end

    assign mode_o = mode_q;
    assign sub_o  = sub_q;

    // R4
    fwu_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        mode_q == MODE_FWU |=> mode_q == MODE_FWU);

    // R3
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        mode_q != 2'b11);

    // R3
    toggle_on_press_chk: assert property (@(posedge clk) disable iff (rst)
        (boot_q && !rise_i) |=> $stable(mode_q));

    // R6
    sub_only_adv_chk: assert property (@(posedge clk) disable iff (rst)
        sub_q != SUB_IDLE |-> mode_q == MODE_ADV);

endmodule

// File: rtl/bsc_led_ctrl.sv
module bsc_led_ctrl
    import bsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode_i,
    input  logic  upl_start_i,
    input  logic  upl_done_i,
    input  logic  upl_err_i,
    input  logic  prg_start_i,
    input  logic  prg_done_i,
    input  logic  usr_blue_i,
    output rgb_t  led_o
);
    upl_e upl_q;
    logic prog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            upl_q  <= UPL_IDLE;
            prog_q <= 1'b0;
        end else begin
            if (upl_start_i) begin
                upl_q <= UPL_BUSY;
            end else if (upl_q == UPL_BUSY && upl_err_i) begin
                upl_q <= UPL_FAIL;
            end else if (upl_q == UPL_BUSY && upl_done_i) begin
                upl_q <= UPL_IDLE;
            end

            if (mode_i == MODE_DEV) begin
                prog_q <= 1'b0;
            end else if (prg_start_i) begin
                prog_q <= 1'b1;
            end else if (prg_done_i) begin
                prog_q <= 1'b0;
            end
        end
    end

    assign led_o = pick_colour(upl_q, prog_q, mode_i, usr_blue_i);

    // R7
    upl_red_chk: assert property (@(posedge clk) disable iff (rst)
        upl_start_i |=> (led_o.r && !led_o.g));

    // R9
    green_mode_chk: assert property (@(posedge clk) disable iff (rst)
        led_o.g |-> mode_i != MODE_DEV);

    // R8
    dev_prog_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_DEV && $past(mode_i) == MODE_DEV) |-> !led_o.g);

endmodule

// File: rtl/board_status_ctrl.sv
module board_status_ctrl
    import bsc_pkg::*;
#(
    parameter int TICK_DIV   = 4,
    parameter int STABLE_CNT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_i,
    input  logic       upl_start_i,
    input  logic       upl_done_i,
    input  logic       upl_err_i,
    input  logic       prg_start_i,
    input  logic       prg_done_i,
    input  logic [1:0] sub_sel_i,
    input  logic       usr_blue_i,
    output logic [1:0] mode_o,
    output logic [1:0] sub_o,
    output logic       led_r_o,
    output logic       led_g_o,
    output logic       led_b_o
);
    logic  tick;
    logic  deb_lvl, deb_valid, deb_rise;
    mode_e mode;
    sub_e  sub;
    rgb_t  led;

    bsc_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    bsc_debounce #(.STABLE_CNT(STABLE_CNT)) u_deb (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .btn_i   (btn_i),
        .lvl_o   (deb_lvl),
        .valid_o (deb_valid),
        .rise_o  (deb_rise)
    );

    bsc_mode_fsm u_mode (
        .clk       (clk),
        .rst       (rst),
        .lvl_i     (deb_lvl),
        .valid_i   (deb_valid),
        .rise_i    (deb_rise),
        .sub_sel_i (sub_sel_i),
        .mode_o    (mode),
        .sub_o     (sub)
    );

    bsc_led_ctrl u_led (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode),
        .upl_start_i (upl_start_i),
        .upl_done_i  (upl_done_i),
        .upl_err_i   (upl_err_i),
        .prg_start_i (prg_start_i),
        .prg_done_i  (prg_done_i),
        .usr_blue_i  (usr_blue_i),
        .led_o       (led)
    );

    assign mode_o  = mode;
    assign sub_o   = sub;
    assign led_r_o = led.r;
    assign led_g_o = led.g;
    assign led_b_o = led.b;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (mode_o == 2'b00 && sub_o == 2'b00 && !led_r_o && !led_g_o));

endmodule

// File: tb/board_status_ctrl_tb.sv
module board_status_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn = 1'b0;
    logic       u_start = 1'b0, u_done = 1'b0, u_err = 1'b0;
    logic       p_start = 1'b0, p_done = 1'b0;
    logic [1:0] sub_sel = 2'b00;
    logic       blue = 1'b0;
    logic [1:0] mode, sub;
    logic       lr, lg, lb;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // bench model state: upload 0 idle, 1 busy, 2 fail
    int exp_upl = 0;
    bit exp_prog = 1'b0;
    logic [1:0] exp_mode = 2'b00;

    always #2.5 clk = ~clk;

    board_status_ctrl u_dut (
        .clk(clk), .rst(rst), .btn_i(btn),
        .upl_start_i(u_start), .upl_done_i(u_done), .upl_err_i(u_err),
        .prg_start_i(p_start), .prg_done_i(p_done),
        .sub_sel_i(sub_sel), .usr_blue_i(blue),
        .mode_o(mode), .sub_o(sub),
        .led_r_o(lr), .led_g_o(lg), .led_b_o(lb)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_rgb(int upl, bit prog, logic [1:0] m, logic b);
        if (upl != 0)                 return {1'b1, 1'b0, b};
        if (prog && m != 2'b00)       return {1'b1, 1'b1, b};
        if (m != 2'b00)               return {1'b0, 1'b1, b};
        return {1'b0, 1'b0, b};
    endfunction

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic hold_btn);
        @(negedge clk);
        btn = hold_btn;
        rst = 1'b1;
        wait_n(3);
        check("R1 mode in reset", {2'b00, mode}, 4'h0);
        check("R1 led in reset", {1'b0, lr, lg, lb}, 4'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 quiet after reset", {sub, lr, lg}, 4'h0);
        exp_upl = 0;
        exp_prog = 1'b0;
    endtask

    task automatic press();
        btn = 1'b1;
        wait_n(200);
        btn = 1'b0;
        wait_n(200);
    endtask

    // one strobe cycle: drive, let one edge pass, update model, compare
    task automatic step(input int kind, input logic b);
        u_start = (kind == 0); u_done = (kind == 1); u_err = (kind == 2);
        p_start = (kind == 3); p_done = (kind == 4);
        blue = b;
        @(negedge clk);
        case (kind)
            0: exp_upl = 1;
            1: if (exp_upl == 1) exp_upl = 0;
            2: if (exp_upl == 1) exp_upl = 2;
            3: if (exp_mode != 2'b00) exp_prog = 1'b1;
            4: exp_prog = 1'b0;
            default: ;
        endcase
        if (exp_mode == 2'b00) exp_prog = 1'b0;
        u_start = 0; u_done = 0; u_err = 0; p_start = 0; p_done = 0;
        check("R7 R8 R9 R10 led overlay", {1'b0, lr, lg, lb}, {1'b0, exp_rgb(exp_upl, exp_prog, exp_mode, b)});
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));

        // ---- startup with button held: firmware update
        do_reset(1'b1);
        wait_n(300);
        exp_mode = 2'b10;
        check("R2 held at startup -> fwu", {2'b00, mode}, 4'h2);
        check("R9 fwu green", {1'b0, lr, lg, lb}, 4'b0010);
        btn = 1'b0;
        wait_n(200);
        press();
        press();
        check("R4 fwu ignores presses", {2'b00, mode}, 4'h2);
        sub_sel = 2'b11;
        wait_n(2);
        check("R6 sub idle outside adv", {2'b00, sub}, 4'h0);
        step(3, 1'b0);
        check("R8 amber in fwu", {1'b0, lr, lg, lb}, 4'b0110);
        step(5, 1'b0);
        check("R8 amber held without done", {1'b0, lr, lg, lb}, 4'b0110);
        step(4, 1'b0);

        // ---- startup released: development
        do_reset(1'b0);
        exp_mode = 2'b00;
        wait_n(300);
        check("R2 released at startup -> dev", {2'b00, mode}, 4'h0);
        check("R9 dev dark", {1'b0, lr, lg, lb}, 4'h0);
        sub_sel = 2'b10;
        wait_n(2);
        check("R6 sub idle in dev", {2'b00, sub}, 4'h0);
        step(3, 1'b0);
        check("R8 prog ignored in dev", {1'b0, lr, lg, lb}, 4'h0);

        // R10 blue independent
        blue = 1'b1;
        #1;
        check("R10 blue passthrough", {1'b0, lr, lg, lb}, 4'b0001);
        blue = 1'b0;

        // ---- press into advanced
        press();
        exp_mode = 2'b01;
        check("R3 press dev -> adv", {2'b00, mode}, 4'h1);
        check("R9 adv green", {1'b0, lr, lg, lb}, 4'b0010);

        // R5 short glitches
        for (int k = 0; k < 6; k++) begin
            btn = 1'b1;
            wait_n(2);
            btn = 1'b0;
            wait_n(40);
        end
        wait_n(100);
        check("R5 glitch rejected", {2'b00, mode}, 4'h1);

        // R6 sub-command follows in adv
        for (int s = 0; s < 4; s++) begin
            sub_sel = 2'(s);
            @(negedge clk);
            check("R6 sub follows select", {2'b00, sub}, 4'(s));
        end
        sub_sel = 2'b00;

        // R7 error latch
        step(0, 1'b0);
        step(2, 1'b0);
        step(1, 1'b0);
        check("R7 error keeps red through done", {1'b0, lr, lg, lb}, 4'b0100);
        step(0, 1'b0);
        step(1, 1'b0);
        check("R7 restart then done clears", {1'b0, lr, lg, lb}, 4'b0010);

        // R9 priority: upload over amber
        step(3, 1'b0);
        step(0, 1'b1);
        check("R9 upload over amber", {1'b0, lr, lg, lb}, 4'b0101);
        step(1, 1'b0);
        check("R9 amber back after upload", {1'b0, lr, lg, lb}, 4'b0110);
        step(4, 1'b0);

        // R7 start wins over error/done in the same cycle
        u_start = 1'b1; u_err = 1'b1; u_done = 1'b1;
        @(negedge clk);
        u_start = 0; u_err = 0; u_done = 0;
        exp_upl = 1;
        step(1, 1'b0);
        check("R7 start wins, then done clears", {1'b0, lr, lg, lb}, 4'b0010);

        // ---- random strobes in advanced mode
        for (int i = 0; i < 400; i++) begin
            step(int'($urandom_range(0, 9)), 1'($urandom_range(0, 1)));
        end

        // ---- back to development, random there too
        step(1, 1'b0);
        step(4, 1'b0);
        if (exp_upl == 2) step(0, 1'b0);
        step(1, 1'b0);
        press();
        exp_mode = 2'b00;
        exp_prog = 1'b0;
        check("R3 press adv -> dev", {2'b00, mode}, 4'h0);
        for (int i = 0; i < 300; i++) begin
            step(int'($urandom_range(0, 9)), 1'($urandom_range(0, 1)));
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule